// File: doc/BRIEF.md
# Multi-Channel PWM with Qualified Trigger Updates

This block is a bank of pulse-width-modulated outputs driven from a small word-addressed register file. Every channel owns a clock divider, a period count, a duty-high count and an output-inversion bit. Software writes new values into staging registers first. These values reach the running waveform only when the channel's trigger bit makes a qualified rising edge, so a channel can be reprogrammed piece by piece without glitching its output.

A rising edge of a trigger bit counts only if the bit was low for at least `MIN_LOW` clock cycles before it. The bit must then stay high for `MIN_HIGH` cycles. At the end of that high window, the channel takes a snapshot of its staged values, provided the channel's hold bit is clear at that moment. The snapshot becomes active at the next period boundary of the running waveform, so the output never shows a cut-short period. If a trigger edge comes too early, if the trigger drops too soon, or if the hold bit is set, the running waveform is left unchanged.

Software stands in for a disable by loading a zero period, a zero duty and a zero prescale. The output then rests at its inactive level.

Top module: `pwm_trig_bank`

## Requirements
- R1: Register words are addressed by `wr_addr`/`rd_addr`. Word 0 is control, word 1 is prescale, word 2+2c is the period of channel c, and word 3+2c is the duty-high value of channel c. A write happens on a clock edge with `wr_en` high. `rd_data` returns the addressed word, zero-extended, one clock after `rd_addr` is presented.
- R2: In the control word, channel c uses bit 4c as its trigger, bit 4c+1 as its hold bit, and bit 4c+2 as its inversion bit. Its prescale is bits [PS_W*c +: PS_W] of the prescale word. Channels run independently of each other.
- R3: A qualified trigger rise that is then held high for `MIN_HIGH` cycles, with the hold bit clear at the end of that window, loads the staged prescale, period, duty and inversion. The new values appear at the next period boundary.
- R4: A trigger rise that follows fewer than `MIN_LOW` low cycles is ignored. A trigger that falls before `MIN_HIGH` high cycles is also ignored. In both cases the waveform is unchanged.
- R5: While no load takes place (trigger low, hold bit set), writes to the staging registers do not change the output.
- R6: With prescale p, period n and duty d, the output repeats every (p+1)*(n+1) cycles. It is active for (p+1)*min(d, n+1) cycles of each repeat, so a duty above n gives a constant active output.
- R7: A duty of zero, or a period of zero, gives a constant inactive output whatever the other fields hold.
- R8: The inversion bit swaps the active and inactive levels. Normal mode is active high; inverted mode is active low and rests high.
- R9: If the hold bit is set when the high window ends, the trigger loads nothing.
- R10: After a synchronous reset, all registers read zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address for writes |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address for reads |
| rd_data | output | DATA_W | Registered read data |
| pwm_o | output | NCH | One PWM output per channel |

## Verification
Read data is due one clock after the address, so the bench presents the address on a falling edge and compares on the falling edge after that. A waveform change is due up to `MIN_HIGH`+1 cycles after the trigger write, plus at most one old period before the boundary, plus one output register. Each scenario therefore waits `MIN_HIGH`+4 cycles and then a settling time longer than two of the longest periods used. Only after that does it count active cycles over an 80-cycle window, which is a whole multiple of every period used, so the count does not depend on phase.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;
  localparam int CTRL_STRIDE = 4;
  localparam int TRIG_BIT    = 0;
  localparam int HOLD_BIT    = 1;
  localparam int INV_BIT     = 2;
  localparam int WORD_CTRL   = 0;
  localparam int WORD_PRESC  = 1;
  localparam int WORD_CHAN0  = 2;

  function automatic int period_word(input int ch);
    return WORD_CHAN0 + 2 * ch;
  endfunction

  function automatic int duty_word(input int ch);
    return WORD_CHAN0 + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/pwm_trig_regs.sv
module pwm_trig_regs
  import pwm_trig_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PS_W   = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int CTRL_W = NCH * CTRL_STRIDE,
  localparam int PRE_W  = NCH * PS_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [CTRL_W-1:0]          ctrl_q,
  output logic [PRE_W-1:0]           presc_q,
  output logic [NCH-1:0][CNT_W-1:0]  per_q,
  output logic [NCH-1:0][CNT_W-1:0]  duty_q
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      per_q   <= '0;
      duty_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(WORD_CTRL))  ctrl_q  <= wr_data[CTRL_W-1:0];
      if (wr_addr == ADDR_W'(WORD_PRESC)) presc_q <= wr_data[PRE_W-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr == ADDR_W'(period_word(c))) per_q[c]  <= wr_data[CNT_W-1:0];
        if (wr_addr == ADDR_W'(duty_word(c)))   duty_q[c] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(WORD_CTRL))  rd_mux = DATA_W'(ctrl_q);
    if (rd_addr == ADDR_W'(WORD_PRESC)) rd_mux = DATA_W'(presc_q);
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == ADDR_W'(period_word(c))) rd_mux = DATA_W'(per_q[c]);
      if (rd_addr == ADDR_W'(duty_word(c)))   rd_mux = DATA_W'(duty_q[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/pwm_trig_qual.sv
module pwm_trig_qual #(
  parameter int MIN_LOW  = 50,
  parameter int MIN_HIGH = 50,
  localparam int LW = $clog2(MIN_LOW + 1),
  localparam int HW = $clog2(MIN_HIGH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic hold_i,
  output logic go_o
);
  logic          trig_d;
  logic          armed;
  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d   <= 1'b0;
      armed    <= 1'b0;
      low_cnt  <= '0;
      high_cnt <= '0;
      go_o     <= 1'b0;
    end else begin
      trig_d <= trig_i;
      go_o   <= 1'b0;
      if (!trig_i) begin
        armed    <= 1'b0;
        high_cnt <= '0;
        if (low_cnt != LW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
      end else if (!trig_d) begin
        armed    <= (low_cnt == LW'(MIN_LOW));
        high_cnt <= HW'(1);
        low_cnt  <= '0;
      end else if (armed && high_cnt != HW'(MIN_HIGH)) begin
        high_cnt <= high_cnt + 1'b1;
        if (high_cnt == HW'(MIN_HIGH - 1)) go_o <= !hold_i;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int PS_W  = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [PS_W-1:0]  st_ps,
  input  logic [CNT_W-1:0] st_per,
  input  logic [CNT_W-1:0] st_duty,
  input  logic             st_inv,
  output logic             pwm_o,
  output logic             idle_o,
  output logic             inv_o
);
  logic             pend_v, pend_inv, act_inv;
  logic [PS_W-1:0]  pend_ps, act_ps, pcnt;
  logic [CNT_W-1:0] pend_per, pend_duty, act_per, act_duty, cnt;
  logic             tick, bnd, active;

  assign tick   = (pcnt == act_ps);
  assign bnd    = tick && (cnt == act_per);
  assign active = (act_per != '0) && (cnt < act_duty);
  assign idle_o = (act_per == '0);
  assign inv_o  = act_inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0; pend_inv <= 1'b0; pend_ps <= '0; pend_per <= '0; pend_duty <= '0;
      act_inv <= 1'b0; act_ps <= '0; act_per <= '0; act_duty <= '0;
      pcnt <= '0; cnt <= '0; pwm_o <= 1'b0;
    end else begin
      if (go_i) begin
        pend_v    <= 1'b1;
        pend_ps   <= st_ps;
        pend_per  <= st_per;
        pend_duty <= st_duty;
        pend_inv  <= st_inv;
      end
      if (bnd) begin
        pcnt <= '0;
        cnt  <= '0;
        if (pend_v) begin
          act_ps   <= pend_ps;
          act_per  <= pend_per;
          act_duty <= pend_duty;
          act_inv  <= pend_inv;
          if (!go_i) pend_v <= 1'b0;
        end
      end else if (tick) begin
        pcnt <= '0;
        cnt  <= cnt + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
      pwm_o <= active ^ act_inv;
    end
  end
endmodule

// File: rtl/pwm_trig_bank.sv
module pwm_trig_bank
  import pwm_trig_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int PS_W     = 4,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int MIN_LOW  = 50,
  parameter int MIN_HIGH = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    pwm_o
);
  localparam int CTRL_W = NCH * CTRL_STRIDE;
  localparam int PRE_W  = NCH * PS_W;

  logic [CTRL_W-1:0]         ctrl_q;
  logic [PRE_W-1:0]          presc_q;
  logic [NCH-1:0][CNT_W-1:0] per_q, duty_q;
  logic [NCH-1:0]            trig_v, hold_v, inv_v, go_v, idle_v, pol_v;

  pwm_trig_regs #(
    .NCH(NCH), .PS_W(PS_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_q(ctrl_q), .presc_q(presc_q),
    .per_q(per_q), .duty_q(duty_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign trig_v[c] = ctrl_q[CTRL_STRIDE*c + TRIG_BIT];
    assign hold_v[c] = ctrl_q[CTRL_STRIDE*c + HOLD_BIT];
    assign inv_v[c]  = ctrl_q[CTRL_STRIDE*c + INV_BIT];

    pwm_trig_qual #(.MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH)) u_qual (
      .clk(clk), .rst(rst), .trig_i(trig_v[c]), .hold_i(hold_v[c]), .go_o(go_v[c])
    );

    pwm_chan_core #(.PS_W(PS_W), .CNT_W(CNT_W)) u_core (
      .clk(clk), .rst(rst), .go_i(go_v[c]),
      .st_ps(presc_q[PS_W*c +: PS_W]), .st_per(per_q[c]), .st_duty(duty_q[c]),
      .st_inv(inv_v[c]), .pwm_o(pwm_o[c]), .idle_o(idle_v[c]), .inv_o(pol_v[c])
    );
  end
endmodule

// File: rtl/pwm_trig_bank_chk.sv
module pwm_trig_bank_chk #(
  parameter int NCH     = 4,
  parameter int MIN_LOW = 50,
  localparam int LW = $clog2(MIN_LOW + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] trig,
  input logic [NCH-1:0] hold,
  input logic [NCH-1:0] go,
  input logic [NCH-1:0] idle,
  input logic [NCH-1:0] pol,
  input logic [NCH-1:0] pwm
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [LW-1:0] lowc;
    logic          prev_t, edge_ok;

    always_ff @(posedge clk) begin
      if (rst) begin
        lowc <= '0; prev_t <= 1'b0; edge_ok <= 1'b0;
      end else begin
        prev_t <= trig[c];
        if (!trig[c]) begin
          if (lowc != LW'(MIN_LOW)) lowc <= lowc + 1'b1;
        end else begin
          lowc <= '0;
          if (!prev_t) edge_ok <= (lowc == LW'(MIN_LOW));
        end
      end
    end

    AST_LOAD_NEEDS_TRIG: assert property (@(posedge clk) disable iff (rst)
      go[c] |-> ($past(trig[c]) && !$past(hold[c]))); // R3
    AST_LOAD_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
      go[c] |-> edge_ok); // R4
    AST_ONE_LOAD_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
      go[c] |=> !go[c]); // R4
    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
      $past(idle[c]) |-> (pwm[c] == $past(pol[c]))); // R7
  end
endmodule

bind pwm_trig_bank pwm_trig_bank_chk #(.NCH(NCH), .MIN_LOW(MIN_LOW)) u_chk (
  .clk(clk), .rst(rst), .trig(trig_v), .hold(hold_v), .go(go_v),
  .idle(idle_v), .pol(pol_v), .pwm(pwm_o)
);

// File: tb/sim_pwm_trig_bank.sv
module sim_pwm_trig_bank;
  localparam int NCH = 4, PS_W = 4, CNT_W = 16, DATA_W = 32, ADDR_W = 4;
  localparam int MIN_LOW = 50, MIN_HIGH = 50, WIN = 80;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [NCH-1:0]    pwm_o;

  int total = 0, bad = 0;
  logic [31:0] ctrl_sh = '0, presc_sh = '0;

  always #4 clk = ~clk;

  pwm_trig_bank #(.NCH(NCH), .PS_W(PS_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    @(negedge clk); rd_addr = ADDR_W'(a);
    @(negedge clk); check(tag, int'(rd_data), exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int ch, output int hi);
    hi = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      hi += int'(pwm_o[ch]);
    end
  endtask

  task automatic set_ctrl(input int ch, input bit trig, input bit hold, input bit inv);
    ctrl_sh[4*ch]   = trig;
    ctrl_sh[4*ch+1] = hold;
    ctrl_sh[4*ch+2] = inv;
    wr(0, ctrl_sh);
  endtask

  task automatic stage(input int ch, input int ps, input int per, input int duty);
    presc_sh[PS_W*ch +: PS_W] = PS_W'(ps);
    wr(1, presc_sh);
    wr(2 + 2*ch, per);
    wr(3 + 2*ch, duty);
  endtask

  task automatic apply(input int ch, input int ps, input int per, input int duty, input bit inv);
    set_ctrl(ch, 1'b0, 1'b1, ctrl_sh[4*ch+2]);
    wait_cyc(MIN_LOW + 4);
    stage(ch, ps, per, duty);
    set_ctrl(ch, 1'b1, 1'b0, inv);
    wait_cyc(MIN_HIGH + 4);
    wait_cyc(60);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NCH; c++) check("R10 output low after reset", int'(pwm_o[c]), 0);
    rd_chk("R10 control reads zero", 0, 0);
    rd_chk("R10 duty ch3 reads zero", 9, 0);
  endtask

  task automatic t_regs;
    wr(4, 32'h1234);
    rd_chk("R1 period ch1 readback", 4, 32'h1234);
    wr(4, 0);
    rd_chk("R1 period ch1 cleared", 4, 0);
  endtask

  task automatic t_basic;
    int hi;
    apply(0, 1, 9, 4, 1'b0);
    measure(0, hi); check("R3 R6 ch0 p1 n9 d4", hi, 32);
    measure(1, hi); check("R2 ch1 untouched", hi, 0);
  endtask

  task automatic t_hold_stage;
    int hi;
    set_ctrl(0, 1'b0, 1'b1, 1'b0);
    stage(0, 1, 9, 8);
    wait_cyc(MIN_LOW + 10);
    measure(0, hi); check("R5 staged write hidden", hi, 32);
    set_ctrl(0, 1'b1, 1'b0, 1'b0);
    wait_cyc(MIN_HIGH + 64);
    measure(0, hi); check("R3 trigger loads d8", hi, 64);
  endtask

  task automatic t_bad_edges;
    int hi;
    stage(0, 1, 9, 2);
    set_ctrl(0, 1'b0, 1'b0, 1'b0);
    wait_cyc(10);
    set_ctrl(0, 1'b1, 1'b0, 1'b0);
    wait_cyc(MIN_HIGH + 20);
    measure(0, hi); check("R4 short low ignored", hi, 64);
    set_ctrl(0, 1'b0, 1'b0, 1'b0);
    wait_cyc(MIN_LOW + 10);
    set_ctrl(0, 1'b1, 1'b0, 1'b0);
    wait_cyc(10);
    set_ctrl(0, 1'b0, 1'b0, 1'b0);
    wait_cyc(MIN_HIGH + 30);
    measure(0, hi); check("R4 short high ignored", hi, 64);
    wait_cyc(MIN_LOW + 4);
    set_ctrl(0, 1'b1, 1'b1, 1'b0);
    wait_cyc(MIN_HIGH + 30);
    measure(0, hi); check("R9 hold set blocks load", hi, 64);
    apply(0, 1, 9, 2, 1'b0);
    measure(0, hi); check("R3 load after clean edge d2", hi, 16);
  endtask

  task automatic t_shapes;
    int hi;
    apply(0, 1, 9, 4, 1'b1);
    measure(0, hi); check("R8 inverted d4", hi, 48);
    apply(0, 1, 9, 15, 1'b0);
    measure(0, hi); check("R6 duty above period full", hi, 80);
    apply(0, 1, 9, 0, 1'b0);
    measure(0, hi); check("R7 duty zero", hi, 0);
    apply(0, 0, 0, 5, 1'b0);
    measure(0, hi); check("R7 period zero", hi, 0);
    apply(0, 0, 0, 5, 1'b1);
    measure(0, hi); check("R7 R8 period zero inverted rests high", hi, 80);
  endtask

  task automatic t_multi;
    int hi;
    apply(2, 0, 4, 2, 1'b0);
    apply(3, 3, 1, 1, 1'b0);
    measure(2, hi); check("R2 ch2 p0 n4 d2", hi, 32);
    measure(3, hi); check("R2 ch3 prescale field p3", hi, 40);
    measure(0, hi); check("R2 ch0 kept", hi, 80);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_regs();
    t_basic();
    t_hold_stage();
    t_bad_edges();
    t_shapes();
    t_multi();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule